// File: doc/BRIEF.md
# Sorted Request Grant Allocator

The allocator receives one slot's worth of switch requests on N lanes, N a power of two. Each lane carries an activity bit and a destination outlet number. The lanes arrive already ordered by destination, so every request for one outlet occupies a contiguous run of lanes, and idle lanes follow all active ones. The interconnection can deliver up to K requests per outlet in a slot, so the allocator admits the first K requests of each run in lane order and refuses the rest. For each lane it reports a granted flag and a grant index. The index tells the winning lane which of the K paths toward its outlet it owns.

The count runs as a segmented running sum over log2(K) adder stages. Each stage doubles the look-back distance, so a lane never examines more than K lanes above it. The whole result is captured into registers on a valid strobe and appears one clock later.

Top module: `srga_top`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, every `gnt_ok` bit is 0 and `gnt_idx` is all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: An active lane is granted exactly when fewer than K active lanes above it carry the same destination. This caps each outlet at K grants per slot.
- R4: A granted lane's index, `gnt_idx[i*KL +: KL]` with KL = log2(K), equals the number of active same-destination lanes above it. Within a run the indices are therefore 0, 1, ..., K-1 in lane order.
- R5: An idle lane (`req_act[i]` = 0) is never granted, and its index is 0.
- R6: A refused active lane has index 0.
- R7: A run starts at lane 0, or at any lane whose destination differs from the lane above it. The count restarts at that lane, so an active lane 0 is always granted with index 0.
- R8: While `in_valid` is low, the outputs `gnt_ok` and `gnt_idx` keep their values, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request set on the lanes is valid this cycle |
| req_act | input | N | Activity bit per lane; bit i belongs to lane i |
| req_dst | input | N*log2(N) | Destination per lane; lane i at bits [i*log2(N) +: log2(N)] |
| out_valid | output | 1 | Grant outputs were updated at the last edge |
| gnt_ok | output | N | Granted flag per lane |
| gnt_idx | output | N*KL | Grant index per lane; lane i at bits [i*KL +: KL] |

## Verification
The hardest case to reach is a run longer than K that sits directly against a neighbouring run, an idle tail, or lane 0. The count must then saturate at the K-th request and restart exactly at the boundary. A correct result also depends on the full depth of the adder chain. Random request sets leave these cases to chance, so the stimulus builds them directly: all lanes for one outlet, three requests for one outlet next to other runs, many one-lane runs, and all-idle sets. Random sorted sets with varied active counts and deliberately narrow destination ranges follow, so that long runs come up often.

// File: rtl/srga_pkg.sv
// Package: shared defaults for the sorted request grant allocator.
// Assumes lane counts and speed-up values are powers of two.
package srga_pkg;
    localparam int unsigned SRGA_DEF_LANES   = 8;
    localparam int unsigned SRGA_DEF_SPEEDUP = 2;

    // Number of bits to encode v-1 for v >= 2 (grant index width).
    function automatic int unsigned srga_idx_w(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction
endpackage

// File: rtl/srga_link.sv
// Module: srga_link
// Flags, per lane, whether the lane above is an active request for the same
// outlet. Assumes lanes are sorted by destination. Lane 0 never links.
module srga_link #(
    parameter int unsigned N  = 8,
    parameter int unsigned DW = 3
) (
    input  logic [N-1:0]    act,
    input  logic [N*DW-1:0] dst,
    output logic [N-1:0]    link
);
    assign link[0] = 1'b0;

    genvar i;
    generate
        for (i = 1; i < N; i++) begin : g_lane
            // Lane i continues the run of lane i-1 when that lane is live and shares the outlet.
            assign link[i] = act[i-1] &&
                             (dst[i*DW +: DW] == dst[(i-1)*DW +: DW]);
        end
    endgenerate
endmodule

// File: rtl/srga_scan_stage.sv
// Module: srga_scan_stage
// One stage of a segmented running-sum adder. Element i absorbs element i-D
// unless a run boundary has already been seen inside element i's window.
// Assumes sums never exceed the width SW (guaranteed by the window size).
module srga_scan_stage #(
    parameter int unsigned N  = 8,
    parameter int unsigned SW = 2,
    parameter int unsigned D  = 1
) (
    input  logic [N*SW-1:0] sum_i,
    input  logic [N-1:0]    stop_i,
    output logic [N*SW-1:0] sum_o,
    output logic [N-1:0]    stop_o
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_el
            if (i >= D) begin : g_add
                // Accumulate the left partner while still inside the run.
                assign sum_o[i*SW +: SW] = stop_i[i] ? sum_i[i*SW +: SW]
                                         : sum_i[i*SW +: SW] + sum_i[(i-D)*SW +: SW];
                assign stop_o[i] = stop_i[i] | stop_i[i-D];
            end else begin : g_pass
                // No partner this far up: carry the partial result unchanged.
                assign sum_o[i*SW +: SW] = sum_i[i*SW +: SW];
                assign stop_o[i] = 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/srga_top.sv
// Module: srga_top
// Sorted request grant allocator. For each active lane it counts, within the
// K lanes above it, the active lanes of the same outlet run, and grants it
// when that count is below K. Results are registered on in_valid.
// Assumes lanes are sorted by destination with idle lanes after active ones.
module srga_top #(
    parameter int unsigned N = srga_pkg::SRGA_DEF_LANES,
    parameter int unsigned K = srga_pkg::SRGA_DEF_SPEEDUP,
    localparam int unsigned DW = $clog2(N),
    localparam int unsigned KL = srga_pkg::srga_idx_w(K),
    localparam int unsigned SW = KL + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [N-1:0]    req_act,
    input  logic [N*DW-1:0] req_dst,
    output logic            out_valid,
    output logic [N-1:0]    gnt_ok,
    output logic [N*KL-1:0] gnt_idx
);
    logic [N-1:0]    link;
    logic [N*SW-1:0] s_sum  [0:KL];
    logic [N-1:0]    s_stop [0:KL];
    logic [N-1:0]    ok_c;
    logic [N*KL-1:0] idx_c;

    srga_link #(.N(N), .DW(DW)) u_link (
        .act  (req_act),
        .dst  (req_dst),
        .link (link)
    );

    genvar i, j;
    generate
        for (i = 0; i < N; i++) begin : g_seed
            // Element i starts with the contribution of lane i-1 to lane i's rank.
            assign s_sum[0][i*SW +: SW] = {{(SW-1){1'b0}}, link[i]};
            assign s_stop[0][i]         = ~link[i];
        end

        for (j = 0; j < KL; j++) begin : g_stage
            srga_scan_stage #(.N(N), .SW(SW), .D(1 << j)) u_stage (
                .sum_i  (s_sum[j]),
                .stop_i (s_stop[j]),
                .sum_o  (s_sum[j+1]),
                .stop_o (s_stop[j+1])
            );
        end

        for (i = 0; i < N; i++) begin : g_dec
            // Grant when the run boundary lies in the window or the count is short of K.
            assign ok_c[i] = req_act[i] &&
                             (s_stop[KL][i] || (s_sum[KL][i*SW +: SW] < SW'(K)));
            assign idx_c[i*KL +: KL] = ok_c[i] ? s_sum[KL][i*SW +: KL] : '0;
        end
    endgenerate

    // Capture the decision on a valid strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            gnt_ok    <= '0;
            gnt_idx   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                gnt_ok  <= ok_c;
                gnt_idx <= idx_c;
            end
        end
    end
endmodule

// File: rtl/srga_chk.sv
// Module: srga_chk
// Property checker for srga_top, attached by bind. Relates the registered
// grants to the request inputs of the previous cycle.
module srga_chk #(
    parameter int unsigned N  = 8,
    parameter int unsigned K  = 2,
    parameter int unsigned DW = 3,
    parameter int unsigned KL = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [N-1:0]    req_act,
    input logic [N*DW-1:0] req_dst,
    input logic            out_valid,
    input logic [N-1:0]    gnt_ok,
    input logic [N*KL-1:0] gnt_idx
);
    logic armed;

    // Marks that one clock has passed since reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid)) |-> ($stable(gnt_ok) && $stable(gnt_idx)));

    p_lane0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid)) |->
        (gnt_ok[0] == $past(req_act[0]) && gnt_idx[KL-1:0] == '0));

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_lane
            p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (armed && $past(in_valid) && !$past(req_act[i])) |-> !gnt_ok[i]);

            p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !gnt_ok[i] |-> (gnt_idx[i*KL +: KL] == '0));

            if (i > 0) begin : g_pair
                p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    (armed && $past(in_valid) && $past(req_act[i-1]) &&
                     ($past(req_dst[i*DW +: DW]) == $past(req_dst[(i-1)*DW +: DW])) &&
                     gnt_ok[i]) |->
                    (gnt_ok[i-1] && gnt_idx[i*KL +: KL] == gnt_idx[(i-1)*KL +: KL] + 1'b1));

                p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (armed && $past(in_valid) && $past(req_act[i]) && $past(req_act[i-1]) &&
                     ($past(req_dst[i*DW +: DW]) == $past(req_dst[(i-1)*DW +: DW])) &&
                     (!gnt_ok[i-1] || gnt_idx[(i-1)*KL +: KL] == KL'(K-1))) |->
                    !gnt_ok[i]);

                p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
                    (armed && $past(in_valid) && $past(req_act[i]) &&
                     ($past(req_dst[i*DW +: DW]) != $past(req_dst[(i-1)*DW +: DW]))) |->
                    (gnt_ok[i] && gnt_idx[i*KL +: KL] == '0));
            end
        end
    endgenerate
endmodule

bind srga_top srga_chk #(.N(N), .K(K), .DW(DW), .KL(KL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .req_act   (req_act),
    .req_dst   (req_dst),
    .out_valid (out_valid),
    .gnt_ok    (gnt_ok),
    .gnt_idx   (gnt_idx)
);

// File: tb/tb_srga_top.sv
// Bench for srga_top: behavioural reference counting earlier same-outlet
// active lanes, compared against the registered outputs each slot.
module tb_srga_top;
    localparam int N  = 8;
    localparam int K  = 2;
    localparam int DW = 3;
    localparam int KL = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [N-1:0]    req_act = '0;
    logic [N*DW-1:0] req_dst = '0;
    logic            out_valid;
    logic [N-1:0]    gnt_ok;
    logic [N*KL-1:0] gnt_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    srga_top #(.N(N), .K(K)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .req_act(req_act), .req_dst(req_dst),
        .out_valid(out_valid), .gnt_ok(gnt_ok), .gnt_idx(gnt_idx)
    );

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v,
                         input int lane);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s lane %0d actual=%0d expected=%0d", req, lane, act_v, exp_v);
        end
    endtask

    // Drive one request set, then compare every lane with the reference.
    task automatic apply(input logic [N-1:0] a, input logic [N*DW-1:0] d);
        int rank;
        bit eg;
        int ei;
        string rq;
        @(negedge clk);
        req_act = a; req_dst = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R2", int'(out_valid), 1, -1);
        for (int i = 0; i < N; i++) begin
            rank = 0;
            for (int j = 0; j < i; j++)
                if (a[j] && d[j*DW +: DW] == d[i*DW +: DW]) rank++;
            eg = a[i] && (rank < K);
            ei = eg ? rank : 0;
            if (!a[i])      rq = "R5";
            else if (!eg)   rq = "R3";
            else if (i == 0 || d[i*DW +: DW] != d[(i-1)*DW +: DW]) rq = "R7";
            else            rq = "R3";
            check(gnt_ok[i] == eg, rq, int'(gnt_ok[i]), int'(eg), i);
            rq = !a[i] ? "R5" : (!eg ? "R6" : "R4");
            check(int'(gnt_idx[i*KL +: KL]) == ei, rq, int'(gnt_idx[i*KL +: KL]), ei, i);
        end
    endtask

    // Change the inputs without the strobe and confirm the outputs stay put.
    task automatic hold_check();
        logic [N-1:0]    ok0;
        logic [N*KL-1:0] ix0;
        ok0 = gnt_ok; ix0 = gnt_idx;
        req_act = ~req_act; req_dst = ~req_dst;
        @(negedge clk);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0, -1);
        check(gnt_ok == ok0, "R8", int'(gnt_ok), int'(ok0), -1);
        check(gnt_idx == ix0, "R8", int'(gnt_idx), int'(ix0), -1);
    endtask

    // Build a sorted set of m active lanes with outlets drawn from [0, span).
    task automatic rand_set(input int m, input int span);
        logic [N-1:0]    a;
        logic [N*DW-1:0] d;
        int v [N];
        int t;
        for (int i = 0; i < N; i++) v[i] = $urandom_range(span - 1);
        for (int i = 0; i < m; i++)
            for (int j = 0; j + 1 < m - i; j++)
                if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
        for (int i = 0; i < N; i++) begin
            a[i] = (i < m);
            d[i*DW +: DW] = DW'(v[i]);
        end
        apply(a, d);
    endtask

    function automatic logic [N*DW-1:0] pack(input int d0, input int d1, input int d2,
        input int d3, input int d4, input int d5, input int d6, input int d7);
        return {DW'(d7), DW'(d6), DW'(d5), DW'(d4), DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0, -1);
        check(gnt_ok == '0, "R1", int'(gnt_ok), 0, -1);
        check(gnt_idx == '0, "R1", int'(gnt_idx), 0, -1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", int'(out_valid), 0, -1);

        apply(8'hFF, pack(3,3,3,3,3,3,3,3));    // one long run
        hold_check();
        apply(8'h3F, pack(1,5,5,5,6,7,0,0));    // third request for outlet 5 refused
        apply(8'hFF, pack(0,1,2,3,4,5,6,7));    // all single-lane runs
        apply(8'h00, pack(2,2,2,2,2,2,2,2));    // all idle, same outlet
        hold_check();
        apply(8'h0F, pack(4,4,4,4,4,4,4,4));    // long run then idle tail of same outlet
        apply(8'hFF, pack(0,0,0,1,1,1,2,2));    // adjacent long runs
        apply(8'h01, pack(7,0,0,0,0,0,0,0));    // lane 0 alone

        for (int n = 0; n < 400; n++) begin
            rand_set($urandom_range(N), (n % 3 == 0) ? 2 : ((n % 3 == 1) ? 4 : N));
            if (n % 50 == 0) hold_check();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule